// File: doc/BRIEF.md
# DMA Transmit Byte Packer

This block collects a burst of bytes from an external DMA engine and packs them into a bank of nine 16-bit word registers, which the local processor then reads at random. The DMA side sees only a single byte-wide write port: each accepted byte lands at the next position of a running sequence. Position 0 is the low half of word 0, position 1 is the high half of word 0, position 2 is the low half of word 1, and so on. The processor reads any word by address, whether or not a transfer is in progress.

A transfer ("bulk") is opened by writing its byte count. The block then raises its DMA request and a busy flag. It accepts bytes while the active-low acknowledge is held low. After the last counted byte it drops the request and busy, and raises a maskable completion interrupt. The block only operates while the mode input selects DMA operation. Illegal count writes are refused and recorded in a sticky error flag. One clear input resets both the completion flag and the error flag.

Top module: `txpk_top`

## Requirements
- R1: After synchronous reset, `tx_busy`, `dma_req`, `irq` and `err` are 0 and every word reads 0.
- R2: A count write with `cfg_dma_mode`=1, the block idle and a value from 1 to 18 sets `tx_busy` and `dma_req` to 1 on the following cycle.
- R3: The k-th accepted byte of a bulk (k from 0) is stored in word k/2, in bits 7:0 when k is even and in bits 15:8 when k is odd. The other half of that word is left unchanged.
- R4: A byte strobe while `dma_ack_n` is 1 is ignored. No word changes, and the bulk still needs its full remaining count.
- R5: The cycle after the count-th byte is accepted, `tx_busy` and `dma_req` are 0 and the completion flag is set.
- R6: `irq` is 1 while the completion flag is set and `irq_mask` was 0 at the preceding clock edge. With `irq_mask`=1, `irq` is 0.
- R7: A count write of 0 or of more than 18 sets `err` and starts no bulk.
- R8: A count write while busy sets `err` and leaves the running bulk, its remaining count and its byte position unchanged.
- R9: Byte strobes while no bulk is open are dropped, so bytes beyond the programmed count never alter any word.
- R10: With `cfg_dma_mode`=0, count writes are ignored (no busy, no error) and byte strobes change no word.
- R11: `cpu_rdata` shows word `cpu_addr` combinationally for addresses 0 to 8. Addresses 9 and above read 0.
- R12: `flag_clr` clears the completion flag (and so `irq`) and `err`. An accepted count write also clears the completion flag.
- R13: Every new bulk restarts at the low half of word 0, overwriting from there. Words beyond its count keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_mode | input | 1 | 1 enables the DMA packing function |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 5 | Byte count of the next bulk |
| dma_req | output | 1 | Request to the DMA engine |
| dma_ack_n | input | 1 | Active-low acknowledge gating byte writes |
| dma_wr | input | 1 | DMA byte write strobe |
| dma_wdata | input | 8 | DMA byte data |
| cpu_addr | input | 4 | Processor word address |
| cpu_rdata | output | 16 | Processor read data |
| tx_busy | output | 1 | Bulk in progress |
| irq_mask | input | 1 | 1 suppresses the completion interrupt |
| irq | output | 1 | Completion interrupt |
| err | output | 1 | Sticky illegal-count error |
| flag_clr | input | 1 | Clears the completion and error flags |

## Verification
The properties assume that the DMA engine never strobes a byte in the same cycle as a count write. They also assume that `flag_clr` is not pulsed in the cycle that closes a bulk. The stimulus keeps to both rules by issuing each count write, each byte and each clear in a cycle of its own. The bench sweeps every legal bulk length from 1 to 18 against an arithmetic model of where each byte must land. It adds the illegal counts 0, 19 and 31, and repeats strobes with acknowledge high, with no bulk open and with the mode bit off.

// File: rtl/txpk_pkg.sv
package txpk_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    // one byte travelling from the control path into the word bank
    typedef struct packed {
        logic              hit;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } lane_wr_t;

    typedef enum logic [1:0] {
        CV_IDLE   = 2'd0,
        CV_TAKE   = 2'd1,
        CV_REJECT = 2'd2
    } cnt_verdict_e;

    // decide what a count write does this cycle
    function automatic cnt_verdict_e judge_count(
        input logic        wr,
        input logic        mode,
        input logic        busy,
        input int unsigned value,
        input int unsigned limit
    );
        if (!wr || !mode)
            return CV_IDLE;
        if (busy || value == 0 || value > limit)
            return CV_REJECT;
        return CV_TAKE;
    endfunction

    // even byte positions fill the low half, odd ones the high half
    function automatic logic upper_half(input int unsigned pos);
        return pos[0];
    endfunction

endpackage

// File: rtl/txpk_ctrl.sv
module txpk_ctrl
    import txpk_pkg::*;
#(
    parameter int NUM_WORDS = 9
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 mode,
    input  logic                                 cnt_wr,
    input  logic [$clog2(2*NUM_WORDS+1)-1:0]     cnt_val,
    input  logic                                 dma_ack_n,
    input  logic                                 dma_wr,
    input  logic [BYTE_W-1:0]                    dma_data,
    input  logic                                 irq_mask,
    input  logic                                 flag_clr,
    output logic                                 busy,
    output logic                                 irq,
    output logic                                 err,
    output lane_wr_t                             lane,
    output logic [NUM_WORDS-1:0]                 word_sel
);

    localparam int NBYTES = 2 * NUM_WORDS;
    localparam int CW     = $clog2(NBYTES + 1);
    localparam int PW     = $clog2(NBYTES);

    logic [CW-1:0] left_q;
    logic [PW-1:0] ptr_q;
    logic          busy_q;
    logic          done_q;
    logic          err_q;
    logic          irq_q;

    cnt_verdict_e  verdict;
    logic          take_byte;
    logic          last_byte;
    logic          done_next;
    logic          err_next;

    always_comb begin
        verdict   = judge_count(cnt_wr, mode, busy_q, 32'(cnt_val), NBYTES);
        take_byte = busy_q && mode && dma_wr && !dma_ack_n;
        last_byte = take_byte && (left_q == CW'(1));

        if (last_byte)
            done_next = 1'b1;
        else if (flag_clr || verdict == CV_TAKE)
            done_next = 1'b0;
        else
            done_next = done_q;

        if (verdict == CV_REJECT)
            err_next = 1'b1;
        else if (flag_clr)
            err_next = 1'b0;
        else
            err_next = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            ptr_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            done_q <= done_next;
            err_q  <= err_next;
            irq_q  <= done_next && !irq_mask;
            if (verdict == CV_TAKE) begin
                busy_q <= 1'b1;
                left_q <= cnt_val;
                ptr_q  <= '0;
            end else if (take_byte) begin
                left_q <= left_q - CW'(1);
                ptr_q  <= ptr_q + PW'(1);
                if (last_byte)
                    busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        lane.hit  = take_byte;
        lane.hi   = upper_half(32'(ptr_q));
        lane.data = dma_data;
    end

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_sel
        assign word_sel[gi] = take_byte && (ptr_q[PW-1:1] == (PW-1)'(gi));
    end

    assign busy = busy_q;
    assign irq  = irq_q;
    assign err  = err_q;

endmodule

// File: rtl/txpk_store.sv
module txpk_store
    import txpk_pkg::*;
#(
    parameter int NUM_WORDS = 9
) (
    input  logic                          clk,
    input  logic                          rst,
    input  lane_wr_t                      lane,
    input  logic [NUM_WORDS-1:0]          word_sel,
    output logic [NUM_WORDS*WORD_W-1:0]   word_bus
);

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
        logic [BYTE_W-1:0] lo_q;
        logic [BYTE_W-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (word_sel[gi] && lane.hit) begin
                if (lane.hi)
                    hi_q <= lane.data;
                else
                    lo_q <= lane.data;
            end
        end

        assign word_bus[gi*WORD_W +: WORD_W] = {hi_q, lo_q};
    end

endmodule

// File: rtl/txpk_rdmux.sv
module txpk_rdmux
    import txpk_pkg::*;
#(
    parameter int NUM_WORDS = 9,
    parameter int AW        = 4
) (
    input  logic [NUM_WORDS*WORD_W-1:0]   word_bus,
    input  logic [AW-1:0]                 addr,
    output logic [WORD_W-1:0]             rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (addr == AW'(i))
                rdata = word_bus[i*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/txpk_top.sv
module txpk_top
    import txpk_pkg::*;
#(
    parameter int NUM_WORDS = 9,
    localparam int CW = $clog2(2*NUM_WORDS + 1),
    localparam int AW = $clog2(NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_dma_mode,
    input  logic                 cnt_wr,
    input  logic [CW-1:0]        cnt_wdata,
    output logic                 dma_req,
    input  logic                 dma_ack_n,
    input  logic                 dma_wr,
    input  logic [BYTE_W-1:0]    dma_wdata,
    input  logic [AW-1:0]        cpu_addr,
    output logic [WORD_W-1:0]    cpu_rdata,
    output logic                 tx_busy,
    input  logic                 irq_mask,
    output logic                 irq,
    output logic                 err,
    input  logic                 flag_clr
);

    lane_wr_t                      lane;
    logic [NUM_WORDS-1:0]          word_sel;
    logic [NUM_WORDS*WORD_W-1:0]   word_bus;
    logic                          busy;

    txpk_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_dma_mode),
        .cnt_wr    (cnt_wr),
        .cnt_val   (cnt_wdata),
        .dma_ack_n (dma_ack_n),
        .dma_wr    (dma_wr),
        .dma_data  (dma_wdata),
        .irq_mask  (irq_mask),
        .flag_clr  (flag_clr),
        .busy      (busy),
        .irq       (irq),
        .err       (err),
        .lane      (lane),
        .word_sel  (word_sel)
    );

    txpk_store #(.NUM_WORDS(NUM_WORDS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .lane     (lane),
        .word_sel (word_sel),
        .word_bus (word_bus)
    );

    txpk_rdmux #(.NUM_WORDS(NUM_WORDS), .AW(AW)) u_rdmux (
        .word_bus (word_bus),
        .addr     (cpu_addr),
        .rdata    (cpu_rdata)
    );

    assign dma_req = busy;
    assign tx_busy = busy;

endmodule

// File: rtl/txpk_chk.sv
module txpk_chk #(
    parameter int NUM_WORDS = 9,
    localparam int NBYTES = 2 * NUM_WORDS,
    localparam int CW     = $clog2(NBYTES + 1)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cfg_dma_mode,
    input logic                      cnt_wr,
    input logic [CW-1:0]             cnt_wdata,
    input logic                      dma_req,
    input logic                      dma_ack_n,
    input logic                      tx_busy,
    input logic                      irq_mask,
    input logic                      irq,
    input logic                      err,
    input logic [NUM_WORDS*16-1:0]   word_bus
);

    // R2
    cnt_take_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && cfg_dma_mode && !tx_busy && cnt_wdata != '0 && cnt_wdata <= CW'(NBYTES))
        |=> (tx_busy && dma_req));

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && dma_ack_n) |=> (tx_busy && $stable(word_bus)));

    // R9
    idle_store_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |=> $stable(word_bus));

    // R7
    bad_count_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && cfg_dma_mode && (cnt_wdata == '0 || cnt_wdata > CW'(NBYTES))) |=> err);

    // R8
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && cfg_dma_mode && tx_busy) |=> err);

    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq_mask |=> !irq);

    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> (!dma_req && (irq == !$past(irq_mask))));

    // R10
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dma_mode && !tx_busy) |=> (!tx_busy && $stable(word_bus)));

endmodule

bind txpk_top txpk_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_dma_mode (cfg_dma_mode),
    .cnt_wr       (cnt_wr),
    .cnt_wdata    (cnt_wdata),
    .dma_req      (dma_req),
    .dma_ack_n    (dma_ack_n),
    .tx_busy      (tx_busy),
    .irq_mask     (irq_mask),
    .irq          (irq),
    .err          (err),
    .word_bus     (word_bus)
);

// File: tb/sim_txpk_top.sv
`timescale 1ns/1ps
module sim_txpk_top;

    localparam int NW = 9;
    localparam int NB = 18;
    localparam int CW = 5;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_dma_mode = 1'b1;
    logic          cnt_wr = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          dma_req;
    logic          dma_ack_n = 1'b1;
    logic          dma_wr = 1'b0;
    logic [7:0]    dma_wdata = '0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0]   cpu_rdata;
    logic          tx_busy;
    logic          irq_mask = 1'b0;
    logic          irq;
    logic          err;
    logic          flag_clr = 1'b0;

    logic [15:0] exp_w [NW];
    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    txpk_top u0 (
        .clk (clk), .rst (rst), .cfg_dma_mode (cfg_dma_mode),
        .cnt_wr (cnt_wr), .cnt_wdata (cnt_wdata), .dma_req (dma_req),
        .dma_ack_n (dma_ack_n), .dma_wr (dma_wr), .dma_wdata (dma_wdata),
        .cpu_addr (cpu_addr), .cpu_rdata (cpu_rdata), .tx_busy (tx_busy),
        .irq_mask (irq_mask), .irq (irq), .err (err), .flag_clr (flag_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_count(input int v);
        cnt_wr = 1'b1;
        cnt_wdata = CW'(v);
        cyc();
        cnt_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic ackn);
        dma_wr = 1'b1;
        dma_wdata = b;
        dma_ack_n = ackn;
        cyc();
        dma_wr = 1'b0;
        dma_ack_n = 1'b1;
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        cyc();
        flag_clr = 1'b0;
    endtask

    task automatic check_words(input string req);
        for (int i = 0; i < NW; i++) begin
            cpu_addr = AW'(i);
            #1;
            chk(req, 32'(cpu_rdata), 32'(exp_w[i]));
        end
    endtask

    function automatic logic [7:0] byte_of(input int n, input int k, input int seed);
        return 8'((seed * 37 + k * 11 + n * 5 + 3) & 255);
    endfunction

    // push n accepted bytes, updating the model; busy must hold until the last
    task automatic feed(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = byte_of(n, k, seed);
            push(b, 1'b0);
            if (k % 2 == 1) exp_w[k/2][15:8] = b;
            else            exp_w[k/2][7:0]  = b;
            if (k < n - 1) chk("R5 busy before last byte", 32'(tx_busy), 32'd1);
        end
        chk("R5 busy after last byte", 32'(tx_busy), 32'd0);
        chk("R5 req after last byte", 32'(dma_req), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) exp_w[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc();

        // R1 reset state
        chk("R1 busy", 32'(tx_busy), 32'd0);
        chk("R1 req", 32'(dma_req), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        check_words("R1 words");

        // sweep every legal bulk length (R2 R3 R5 R6 R12 R13)
        for (int n = 1; n <= NB; n++) begin
            irq_mask = (n % 4 == 0);
            load_count(n);
            chk("R2 busy", 32'(tx_busy), 32'd1);
            chk("R2 req", 32'(dma_req), 32'd1);
            feed(n, n);
            chk("R6 irq", 32'(irq), 32'(!irq_mask));
            check_words("R3 R13 placement");
            clear_flags();
            chk("R12 irq cleared", 32'(irq), 32'd0);
        end
        irq_mask = 1'b0;

        // R4 strobes with acknowledge high are ignored
        load_count(3);
        for (int j = 0; j < 3; j++) push(8'hAA, 1'b1);
        chk("R4 still busy", 32'(tx_busy), 32'd1);
        check_words("R4 words untouched");
        feed(3, 77);
        check_words("R4 bulk after hold");
        clear_flags();

        // R8 count write while busy
        load_count(4);
        load_count(2);
        chk("R8 err", 32'(err), 32'd1);
        chk("R8 busy kept", 32'(tx_busy), 32'd1);
        feed(4, 91);
        check_words("R8 bulk intact");
        clear_flags();
        chk("R12 err cleared", 32'(err), 32'd0);

        // R7 illegal counts
        begin
            int bad [3] = '{0, 19, 31};
            for (int j = 0; j < 3; j++) begin
                load_count(bad[j]);
                chk("R7 err", 32'(err), 32'd1);
                chk("R7 no bulk", 32'(tx_busy), 32'd0);
                clear_flags();
                chk("R12 err clear", 32'(err), 32'd0);
            end
        end

        // R9 bytes beyond the count are dropped
        for (int j = 0; j < 3; j++) push(8'h55, 1'b0);
        chk("R9 idle", 32'(tx_busy), 32'd0);
        check_words("R9 words untouched");

        // R10 mode bit off
        cfg_dma_mode = 1'b0;
        load_count(5);
        chk("R10 busy", 32'(tx_busy), 32'd0);
        chk("R10 err", 32'(err), 32'd0);
        push(8'h77, 1'b0);
        check_words("R10 words untouched");
        cfg_dma_mode = 1'b1;

        // R11 addresses beyond the bank read zero
        for (int a = NW; a < 16; a++) begin
            cpu_addr = AW'(a);
            #1;
            chk("R11 out of range", 32'(cpu_rdata), 32'd0);
        end

        // R12 new count clears completion
        load_count(2);
        feed(2, 5);
        chk("R6 irq unmasked", 32'(irq), 32'd1);
        load_count(2);
        chk("R12 irq cleared by count", 32'(irq), 32'd0);
        feed(2, 6);
        check_words("R13 restart");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule